// File: doc/BRIEF.md
# Threshold-Integrating Lock Detector

This block decides whether a tracking loop has settled by filtering a stream of pass/fail tests rather than trusting any single sample. Each time the loop delivers a new signed phase error, the block takes its absolute value and compares it with a programmable threshold. An error whose magnitude is at least the threshold is treated as a miss and pulls a saturating signed integrator down by a programmable step. A smaller error is treated as a hit and pushes the integrator up by a separate programmable step.

The integrator starts at its most negative value after reset. The lock indication is high while the integrator is zero or positive, which is the same as its sign bit being clear. Hits must therefore outweigh misses for some time before lock is declared. The two step sizes set how fast the indication reacts and how far it leans in each direction. A select input can route an external lock status to the output in place of the integrator result. A one-cycle event marks each rising edge of the output so that interrupt logic can record it.

Top module: `lock_detector`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `lock_o` and `lock_rise_o` are low and the integrator holds its most negative value, -2^(ACC_W-1).
- R2: On a valid update, the magnitude is taken as the two's-complement absolute value of `perr_i`. When that magnitude is at least `thresh_i`, `step_dn_i` is subtracted from the integrator. A negative error counts the same as a positive error of equal size.
- R3: On a valid update where the magnitude is below `thresh_i`, `step_up_i` is added to the integrator.
- R4: In a cycle where `perr_valid_i` is low, the integrator keeps its value, whatever `perr_i` and the steps are.
- R5: The integrator saturates at 2^(ACC_W-1)-1 and at -2^(ACC_W-1). It never wraps.
- R6: With `ext_sel_i` low, `lock_o` is 1 exactly when the integrator is non-negative. It changes in the cycle after the clock edge that samples the update.
- R7: With `ext_sel_i` high, `lock_o` follows `ext_lock_i` in the same cycle. Integrator updates do not reach the output, but they continue internally.
- R8: `lock_rise_o` is high for exactly one cycle, in the first cycle in which `lock_o` is 1 after a cycle in which it was 0. A falling `lock_o` produces no event.
- R9: A magnitude exactly equal to the threshold counts as a miss. This also holds at the largest threshold, 2^THR_W-1, and for the most negative error, -2^(PERR_W-1), which always counts as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perr_valid_i | input | 1 | Phase error update strobe |
| perr_i | input | PERR_W (22) | Signed phase error |
| thresh_i | input | THR_W (21) | Unsigned magnitude threshold |
| step_up_i | input | STEP_W (16) | Unsigned increment for an error below the threshold |
| step_dn_i | input | STEP_W (16) | Unsigned decrement for an error at or above the threshold |
| ext_sel_i | input | 1 | 1 selects the external lock status for the output |
| ext_lock_i | input | 1 | External lock status |
| lock_o | output | 1 | Lock indication |
| lock_rise_o | output | 1 | One-cycle pulse on each rising edge of lock_o |

## Verification
An update presented with `perr_valid_i` is captured at the next rising edge. Its effect on `lock_o` and on `lock_rise_o` is visible from that edge until the following one. The bench therefore drives each update at a falling edge, drops the strobe at the next falling edge, and samples both outputs at that same point. External-select changes act combinationally, so they are sampled one time step after they are driven. The one-cycle width of the rise event is confirmed at the falling edge after that. Since the integrator cannot be seen directly, its value is inferred from step sequences that place it exactly at 0 or -1, so that a single unit of error flips `lock_o`.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Default widths shared by the lock detector modules
    localparam int DEF_PERR_W = 22;
    localparam int DEF_THR_W  = 21;
    localparam int DEF_ACC_W  = 16;
    localparam int DEF_STEP_W = 16;

    // Outcome of one threshold test
    typedef enum logic {
        VERD_HIT  = 1'b0,   // magnitude below threshold
        VERD_MISS = 1'b1    // magnitude at or above threshold
    } verdict_e;

    // One qualified test result passed to the integrator
    typedef struct packed {
        logic     upd;
        verdict_e verd;
    } test_evt_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lockdet_mag_cmp.sv
module lockdet_mag_cmp
    import lockdet_pkg::*;
#(
    parameter int PERR_W = DEF_PERR_W,
    parameter int THR_W  = DEF_THR_W
) (
    input  logic              valid_i,
    input  logic [PERR_W-1:0] perr_i,
    input  logic [THR_W-1:0]  thresh_i,
    output test_evt_t         evt_o
);
    localparam int PAD_W = PERR_W - THR_W;

    logic [PERR_W-1:0] mag;
    logic [PERR_W-1:0] thr_x;

    // Absolute value; the most negative code maps to 2^(PERR_W-1),
    // which still fits the unsigned PERR_W-bit result.
    always_comb begin
        if (perr_i[PERR_W-1]) mag = (~perr_i) + 1'b1;
        else                  mag = perr_i;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign thr_x = {{PAD_W{1'b0}}, thresh_i};
        end else begin : g_nopad
            assign thr_x = thresh_i[PERR_W-1:0];
        end
    endgenerate

    always_comb begin
        evt_o.upd  = valid_i;
        evt_o.verd = (mag >= thr_x) ? VERD_MISS : VERD_HIT;
    end

endmodule

// File: rtl/lockdet_integrator.sv
module lockdet_integrator
    import lockdet_pkg::*;
#(
    parameter int ACC_W  = DEF_ACC_W,
    parameter int STEP_W = DEF_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  test_evt_t         evt_i,
    input  logic [STEP_W-1:0] step_up_i,
    input  logic [STEP_W-1:0] step_dn_i,
    output logic              negative_o
);
    localparam int EXT_W = max_of(ACC_W, STEP_W) + 2;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [EXT_W-1:0] EXT_MAX =
        $signed({{(EXT_W-ACC_W){1'b0}}, ACC_MAX});
    localparam logic signed [EXT_W-1:0] EXT_MIN =
        $signed({{(EXT_W-ACC_W){1'b1}}, ACC_MIN});

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [EXT_W-1:0] acc_x;
    logic signed [EXT_W-1:0] up_x;
    logic signed [EXT_W-1:0] dn_x;
    logic signed [EXT_W-1:0] sum_x;

    assign acc_x = $signed({{(EXT_W-ACC_W){acc_q[ACC_W-1]}}, acc_q});
    assign up_x  = $signed({{(EXT_W-STEP_W){1'b0}}, step_up_i});
    assign dn_x  = $signed({{(EXT_W-STEP_W){1'b0}}, step_dn_i});

    // Wide sum followed by clamping to the accumulator range
    always_comb begin
        if (evt_i.verd == VERD_MISS) sum_x = acc_x - dn_x;
        else                         sum_x = acc_x + up_x;
        if (sum_x > EXT_MAX)      acc_d = $signed(ACC_MAX);
        else if (sum_x < EXT_MIN) acc_d = $signed(ACC_MIN);
        else                      acc_d = sum_x[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)            acc_q <= $signed(ACC_MIN);
        else if (evt_i.upd) acc_q <= acc_d;
    end

    assign negative_o = acc_q[ACC_W-1];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !evt_i.upd |=> $stable(acc_q)); // R4
    AST_MISS_DOWN: assert property (@(posedge clk) disable iff (rst)
        (evt_i.upd && evt_i.verd == VERD_MISS && step_dn_i != '0 && acc_q != $signed(ACC_MIN))
        |=> (acc_q < $past(acc_q))); // R2
    AST_HIT_UP: assert property (@(posedge clk) disable iff (rst)
        (evt_i.upd && evt_i.verd == VERD_HIT && step_up_i != '0 && acc_q != $signed(ACC_MAX))
        |=> (acc_q > $past(acc_q))); // R3
    AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (evt_i.upd && evt_i.verd == VERD_HIT && acc_q == $signed(ACC_MAX))
        |=> (acc_q == $signed(ACC_MAX))); // R5
    AST_BOTTOM_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (evt_i.upd && evt_i.verd == VERD_MISS && acc_q == $signed(ACC_MIN))
        |=> (acc_q == $signed(ACC_MIN))); // R5

endmodule

// File: rtl/lockdet_rise.sv
module lockdet_rise (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= flag_i;
    end

    assign rise_o = flag_i & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R8

endmodule

// File: rtl/lock_detector.sv
module lock_detector
    import lockdet_pkg::*;
#(
    parameter int PERR_W = DEF_PERR_W,
    parameter int THR_W  = DEF_THR_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int STEP_W = DEF_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              perr_valid_i,
    input  logic [PERR_W-1:0] perr_i,
    input  logic [THR_W-1:0]  thresh_i,
    input  logic [STEP_W-1:0] step_up_i,
    input  logic [STEP_W-1:0] step_dn_i,
    input  logic              ext_sel_i,
    input  logic              ext_lock_i,
    output logic              lock_o,
    output logic              lock_rise_o
);
    test_evt_t evt;
    logic      acc_neg;
    logic      flag;

    lockdet_mag_cmp #(.PERR_W(PERR_W), .THR_W(THR_W)) u_cmp (
        .valid_i  (perr_valid_i),
        .perr_i   (perr_i),
        .thresh_i (thresh_i),
        .evt_o    (evt)
    );

    lockdet_integrator #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_int (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .step_up_i  (step_up_i),
        .step_dn_i  (step_dn_i),
        .negative_o (acc_neg)
    );

    assign flag   = ext_sel_i ? ext_lock_i : ~acc_neg;
    assign lock_o = flag;

    lockdet_rise u_rise (
        .clk    (clk),
        .rst    (rst),
        .flag_i (flag),
        .rise_o (lock_rise_o)
    );

    AST_RESET_UNLOCKED: assert property (@(posedge clk)
        (rst && !ext_sel_i) |=> (!lock_rise_o)); // R1

endmodule

// File: tb/lock_detector_tb_top.sv
module lock_detector_tb_top;
    localparam int PERR_W = 22;
    localparam int THR_W  = 21;
    localparam int STEP_W = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              perr_valid_i;
    logic [PERR_W-1:0] perr_i;
    logic [THR_W-1:0]  thresh_i;
    logic [STEP_W-1:0] step_up_i;
    logic [STEP_W-1:0] step_dn_i;
    logic              ext_sel_i;
    logic              ext_lock_i;
    logic              lock_o;
    logic              lock_rise_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    lock_detector dut_i (
        .clk          (clk),
        .rst          (rst),
        .perr_valid_i (perr_valid_i),
        .perr_i       (perr_i),
        .thresh_i     (thresh_i),
        .step_up_i    (step_up_i),
        .step_dn_i    (step_dn_i),
        .ext_sel_i    (ext_sel_i),
        .ext_lock_i   (ext_lock_i),
        .lock_o       (lock_o),
        .lock_rise_o  (lock_rise_o)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, got, exp);
        end
    endtask

    // One update: driven at a falling edge, captured at the next rising
    // edge, results sampled at the falling edge after that.
    task automatic upd(input int e);
        @(negedge clk);
        perr_i       = PERR_W'(e);
        perr_valid_i = 1'b1;
        @(negedge clk);
        perr_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; perr_valid_i = 0; perr_i = '0; thresh_i = 21'd100;
        step_up_i = 16'd1; step_dn_i = 16'd1; ext_sel_i = 0; ext_lock_i = 0;
        repeat (3) @(negedge clk);
        chk(lock_o, 1'b0, "R1 lock during reset");
        rst = 1'b0;
        @(negedge clk);
        chk(lock_o, 1'b0, "R1 lock after reset");
        chk(lock_rise_o, 1'b0, "R1 rise after reset");
    endtask

    task automatic t_low_clamp();
        step_dn_i = 16'hFFFF;
        upd(500);
        chk(lock_o, 1'b0, "R5 clamp at minimum");
        step_up_i = 16'd32767;
        upd(5);
        chk(lock_o, 1'b0, "R5 no wrap below minimum (now -1)");
        step_up_i = 16'd1;
        upd(5);
        chk(lock_o, 1'b1, "R3 R6 hit reaches zero");
        chk(lock_rise_o, 1'b1, "R8 rise on lock");
        @(negedge clk);
        chk(lock_rise_o, 1'b0, "R8 rise lasts one cycle");
    endtask

    task automatic t_equal();
        step_dn_i = 16'd1; step_up_i = 16'd1;
        upd(100);
        chk(lock_o, 1'b0, "R9 equal magnitude is a miss");
        chk(lock_rise_o, 1'b0, "R8 no event on fall");
        upd(-99);
        chk(lock_o, 1'b1, "R2 negative error below threshold");
        upd(-100);
        chk(lock_o, 1'b0, "R2 R9 negative error equal to threshold");
    endtask

    task automatic t_idle();
        step_up_i = 16'd1;
        @(negedge clk);
        perr_i = PERR_W'(5);
        repeat (5) @(negedge clk);
        chk(lock_o, 1'b0, "R4 no update without valid");
        upd(5);
        chk(lock_o, 1'b1, "R4 update with valid");
    endtask

    task automatic t_high_clamp();
        step_up_i = 16'hFFFF;
        upd(0); upd(0); upd(0);
        chk(lock_o, 1'b1, "R5 clamp at maximum stays locked");
        step_dn_i = 16'd32767;
        upd(-(1 << 21));
        chk(lock_o, 1'b1, "R5 R9 max minus 32767 is zero");
        step_dn_i = 16'd1;
        upd(200);
        chk(lock_o, 1'b0, "R2 one below zero unlocks");
    endtask

    task automatic t_max_thresh();
        thresh_i = 21'h1FFFFF; step_up_i = 16'd1; step_dn_i = 16'd1;
        upd(2097150);
        chk(lock_o, 1'b1, "R3 just below maximum threshold");
        upd(2097151);
        chk(lock_o, 1'b0, "R9 equal to maximum threshold");
        thresh_i = 21'd100;
    endtask

    task automatic t_ext();
        @(negedge clk);
        ext_sel_i = 1'b1; ext_lock_i = 1'b1;
        #1;
        chk(lock_o, 1'b1, "R7 external status shown");
        chk(lock_rise_o, 1'b1, "R8 rise from external status");
        @(negedge clk);
        chk(lock_rise_o, 1'b0, "R8 external rise one cycle");
        step_dn_i = 16'hFFFF;
        upd(5000); upd(5000);
        chk(lock_o, 1'b1, "R7 integrator masked");
        ext_lock_i = 1'b0;
        #1;
        chk(lock_o, 1'b0, "R7 external status falls");
        chk(lock_rise_o, 1'b0, "R8 no event on external fall");
        @(negedge clk);
        ext_sel_i = 1'b0;
        step_up_i = 16'd32767;
        upd(0);
        chk(lock_o, 1'b0, "R7 R5 integrator kept running to minimum");
        step_up_i = 16'd1;
        upd(0);
        chk(lock_o, 1'b1, "R6 integrator output back");
    endtask

    initial begin
        t_reset();
        t_low_clamp();
        t_equal();
        t_idle();
        t_high_clamp();
        t_max_thresh();
        t_ext();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule